// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing heart of a pulse-width modulator. A two-stage clock divider turns the system clock into a slower timebase tick. On each tick a 16-bit counter moves according to one of four modes: it counts up, counts down, counts up then down, or holds still. Other parts of the modulator read the count and two one-cycle event strobes. One strobe marks the counter arriving at zero and the other marks it arriving at the period value. Compare and output logic downstream uses these to shape the waveform.

Software programs the block through two write-enabled words. The control word selects the counting mode, the two divider settings and the period load policy. The period word sets the turning or wrapping value. Period writes can take effect immediately, or they can be staged in a shadow copy that is promoted only when the counter next reaches zero. Staged writes let the period change without a truncated or stretched cycle.

Top module: `pwm_timebase`

## Requirements
- R1: After a synchronous active-high reset the count is 0, the direction flag is 0, both strobes are 0, the mode is hold (3), both divider fields are 0 and the active period is 0.
- R2: The control word fields are: bits 1:0 mode (0 up, 1 down, 2 up-down, 3 hold), bit 3 period load policy, bits 9:7 fine divider, bits 12:10 coarse divider. All other bits have no effect.
- R3: In up mode each tick adds one to the count. A tick at or above the active period wraps the count to 0 instead. The direction flag reads 0.
- R4: In down mode each tick subtracts one from the count. A tick at 0 reloads the active period instead. The direction flag reads 1.
- R5: In up-down mode the count climbs while the direction flag is 0. A tick at or above the period sets the flag to 1 and steps down. A tick at 0 while descending clears the flag and steps up.
- R6: In hold mode the count and direction flag keep their values, and neither strobe is raised.
- R7: A tick occurs once every 2^C × F clock cycles. C is the coarse field. F is 1 when the fine field is 0, and otherwise twice the fine field.
- R8: A control write that changes either divider field restarts the divider. The first tick after the write comes a full new interval after the write edge.
- R9: With bit 3 at 0, a period write goes only to the shadow copy. The shadow copy becomes the active period at the tick that takes the count to 0.
- R10: With bit 3 at 1, a period write updates the active period at the write edge.
- R11: zero_pulse is high for the one cycle after a tick that took the count to 0. period_pulse is high for the one cycle after a tick that took the count to the active period. Both are low on the following cycle if no tick occurs.
- R12: The full 16-bit period 0xFFFF is usable. In down mode a tick at 0 loads 0xFFFF and raises period_pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word value |
| prd_we | input | 1 | Write strobe for the period word |
| prd_wdata | input | 16 | Period value |
| count | output | 16 | Current timebase count |
| dir_down | output | 1 | 1 while the counter is descending |
| zero_pulse | output | 1 | One-cycle strobe: count reached 0 |
| period_pulse | output | 1 | One-cycle strobe: count reached the period |

## Verification
The bench targets the turning points. These are the up-mode wrap, the down-mode reload from zero, and both reversals in up-down mode. A design with an off-by-one compare here would show a count one step off after a known number of ticks, or a direction flag that flips a tick early. Staged and immediate period writes are told apart by the count a few ticks later: a design that promotes the shadow copy too early never wraps at the old period, and one that ignores it keeps wrapping at the old period forever. A divider change partway through an interval checks the restart. A design without the restart ticks early or runs its divider past the new limit. The hold mode and the single-cycle strobes are checked while no tick is due.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    localparam int CTRL_W   = 16;
    localparam int COARSE_W = 3;
    localparam int FINE_W   = 3;
    // widest ratio: 2^7 * 14 = 1792
    localparam int DIV_W    = 11;

    typedef enum logic [1:0] {
        CNT_UP     = 2'd0,
        CNT_DOWN   = 2'd1,
        CNT_UPDN   = 2'd2,
        CNT_FREEZE = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic [2:0]            rsv_hi;
        logic [COARSE_W-1:0]   coarse;
        logic [FINE_W-1:0]     fine;
        logic [2:0]            rsv_mid;
        logic                  imm_load;
        logic                  rsv_lo;
        cnt_mode_e             mode;
    } tb_ctrl_t;

    localparam tb_ctrl_t CTRL_RST = '{
        rsv_hi:   3'd0,
        coarse:   '0,
        fine:     '0,
        rsv_mid:  3'd0,
        imm_load: 1'b0,
        rsv_lo:   1'b0,
        mode:     CNT_FREEZE
    };

    // ratio = 2^coarse * (fine == 0 ? 1 : 2*fine)
    function automatic logic [DIV_W-1:0] div_ratio(
        input logic [COARSE_W-1:0] c,
        input logic [FINE_W-1:0]   f
    );
        logic [DIV_W-1:0] fstage;
        if (f == '0)
            fstage = DIV_W'(1);
        else
            fstage = DIV_W'({f, 1'b0});
        return fstage << c;
    endfunction

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler
    import pwm_tb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic [COARSE_W-1:0] coarse,
    input  logic [FINE_W-1:0]   fine,
    output logic                tick
);

    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] last;
    logic [DIV_W-1:0] div_cnt;

    always_comb begin
        ratio = div_ratio(coarse, fine);
        last  = ratio - DIV_W'(1);
        tick  = (div_cnt >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            div_cnt <= '0;
        else if (tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + DIV_W'(1);
    end

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prd_we,
    input  logic [CNT_W-1:0] prd_wdata,
    input  logic             imm_load,
    input  logic             zero_evt,
    output logic [CNT_W-1:0] prd_active
);

    logic [CNT_W-1:0] prd_shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            prd_shadow <= '0;
            prd_active <= '0;
        end else begin
            if (prd_we) begin
                prd_shadow <= prd_wdata;
                if (imm_load)
                    prd_active <= prd_wdata;
            end
            if (!imm_load && zero_evt)
                prd_active <= prd_shadow;
        end
    end

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             zero_pulse,
    output logic             period_pulse,
    output logic             zero_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] nxt;
    logic             nxt_dir;
    logic             advance;

    always_comb begin
        nxt     = count;
        nxt_dir = dir_down;
        unique case (mode)
            CNT_UP: begin
                nxt_dir = 1'b0;
                nxt     = (count >= prd) ? '0 : count + ONE;
            end
            CNT_DOWN: begin
                nxt_dir = 1'b1;
                nxt     = (count == '0) ? prd : count - ONE;
            end
            CNT_UPDN: begin
                if (!dir_down) begin
                    if (count >= prd) begin
                        nxt_dir = 1'b1;
                        nxt     = (count == '0) ? '0 : count - ONE;
                    end else begin
                        nxt = count + ONE;
                    end
                end else begin
                    if (count == '0) begin
                        nxt_dir = 1'b0;
                        nxt     = (prd == '0) ? '0 : ONE;
                    end else begin
                        nxt = count - ONE;
                    end
                end
            end
            default: begin
                nxt     = count;
                nxt_dir = dir_down;
            end
        endcase
        advance  = tick && (mode != CNT_FREEZE);
        zero_evt = advance && (nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count        <= '0;
            dir_down     <= 1'b0;
            zero_pulse   <= 1'b0;
            period_pulse <= 1'b0;
        end else if (advance) begin
            count        <= nxt;
            dir_down     <= nxt_dir;
            zero_pulse   <= (nxt == '0);
            period_pulse <= (nxt == prd);
        end else begin
            zero_pulse   <= 1'b0;
            period_pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              prd_we,
    input  logic [CNT_W-1:0]  prd_wdata,
    output logic [CNT_W-1:0]  count,
    output logic              dir_down,
    output logic              zero_pulse,
    output logic              period_pulse
);

    tb_ctrl_t         ctrl_q;
    tb_ctrl_t         ctrl_new;
    cnt_mode_e        cur_mode;
    logic             restart;
    logic             tick;
    logic             zero_evt;
    logic [CNT_W-1:0] prd_active;

    always_comb begin
        ctrl_new = tb_ctrl_t'(ctrl_wdata);
        cur_mode = ctrl_q.mode;
        restart  = ctrl_we &&
                   ({ctrl_new.coarse, ctrl_new.fine} != {ctrl_q.coarse, ctrl_q.fine});
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RST;
        else if (ctrl_we)
            ctrl_q <= ctrl_new;
    end

    pwm_tb_prescaler u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .coarse  (ctrl_q.coarse),
        .fine    (ctrl_q.fine),
        .tick    (tick)
    );

    pwm_tb_period #(.CNT_W(CNT_W)) u_prd (
        .clk        (clk),
        .rst        (rst),
        .prd_we     (prd_we),
        .prd_wdata  (prd_wdata),
        .imm_load   (ctrl_q.imm_load),
        .zero_evt   (zero_evt),
        .prd_active (prd_active)
    );

    pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .mode         (cur_mode),
        .prd          (prd_active),
        .count        (count),
        .dir_down     (dir_down),
        .zero_pulse   (zero_pulse),
        .period_pulse (period_pulse),
        .zero_evt     (zero_evt)
    );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             zero_pulse,
    input logic             period_pulse,
    input logic [CNT_W-1:0] prd_active
);

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == CNT_FREEZE) |=> $stable(count)); // R6

    AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == CNT_FREEZE) |=> (!zero_pulse && !period_pulse)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count)); // R7

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
        zero_pulse |-> (count == '0)); // R11

    AST_PRD_MATCH: assert property (@(posedge clk) disable iff (rst)
        period_pulse |-> (count == $past(prd_active))); // R11

    AST_UP_DIR: assert property (@(posedge clk) disable iff (rst)
        (mode == CNT_UP && tick) |=> !dir_down); // R3

    AST_DOWN_DIR: assert property (@(posedge clk) disable iff (rst)
        (mode == CNT_DOWN && tick) |=> dir_down); // R4

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == CNT_UP && tick && count < prd_active) |=>
            (count == $past(count) + CNT_W'(1))); // R3

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode         (cur_mode),
    .tick         (tick),
    .count        (count),
    .dir_down     (dir_down),
    .zero_pulse   (zero_pulse),
    .period_pulse (period_pulse),
    .prd_active   (prd_active)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        prd_we = 1'b0;
    logic [15:0] prd_wdata = '0;
    logic [15:0] count;
    logic        dir_down;
    logic        zero_pulse;
    logic        period_pulse;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pwm_timebase dut (
        .clk          (clk),
        .rst          (rst),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (ctrl_wdata),
        .prd_we       (prd_we),
        .prd_wdata    (prd_wdata),
        .count        (count),
        .dir_down     (dir_down),
        .zero_pulse   (zero_pulse),
        .period_pulse (period_pulse)
    );

    // vectors: mode, coarse, fine, period, cycles, expected count, expected dir
    localparam int NV = 8;
    localparam int V_MODE  [NV] = '{0, 1, 2, 0,  0,   0,   3, 2};
    localparam int V_COARSE[NV] = '{0, 0, 0, 1,  0,   2,   0, 0};
    localparam int V_FINE  [NV] = '{0, 0, 0, 0,  3,   1,   0, 0};
    localparam int V_PRD   [NV] = '{5, 5, 4, 10, 100, 100, 5, 3};
    localparam int V_N     [NV] = '{8, 3, 6, 7,  20,  17,  10, 9};
    localparam int V_CNT   [NV] = '{2, 3, 2, 3,  3,   2,   0, 3};
    localparam int V_DIR   [NV] = '{0, 1, 1, 0,  0,   0,   0, 0};

    function automatic string vec_tag(int i);
        case (i)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R7";
            4: return "R7";
            5: return "R7";
            6: return "R6";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [15:0] mk_ctrl(int mode, int coarse, int fine, int ld);
        return 16'((coarse << 10) | (fine << 7) | (ld << 3) | mode);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(logic [15:0] v);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_prd(logic [15:0] v);
        prd_we = 1'b1;
        prd_wdata = v;
        @(negedge clk);
        prd_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
    endtask

    // returns at the negedge after the edge that applies the final control word
    task automatic start(int mode, int coarse, int fine, int ld, int prd);
        do_reset();
        wr_ctrl(mk_ctrl(3, 0, 0, 1));
        wr_prd(16'(prd));
        wr_ctrl(mk_ctrl(mode, coarse, fine, ld));
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1", "count", int'(count), 0);
        chk("R1", "dir", int'(dir_down), 0);
        chk("R1", "zero_pulse", int'(zero_pulse), 0);
        chk("R1", "period_pulse", int'(period_pulse), 0);
        wait_cyc(4);
        chk("R1", "hold after reset", int'(count), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            start(V_MODE[i], V_COARSE[i], V_FINE[i], 1, V_PRD[i]);
            wait_cyc(V_N[i]);
            chk(vec_tag(i), "vector count", int'(count), V_CNT[i]);
            chk(vec_tag(i), "vector dir", int'(dir_down), V_DIR[i]);
        end

        // R2 reserved bits ignored: up mode, prd 5, reserved bits set
        do_reset();
        wr_ctrl(mk_ctrl(3, 0, 0, 1));
        wr_prd(16'd5);
        wr_ctrl(mk_ctrl(0, 0, 0, 1) | 16'hE074);
        wait_cyc(3);
        chk("R2", "reserved bits ignored", int'(count), 3);

        // R11 strobes, up mode prd 3 ratio 1
        start(0, 0, 0, 1, 3);
        wait_cyc(3);
        chk("R11", "count at period", int'(count), 3);
        chk("R11", "period_pulse", int'(period_pulse), 1);
        wait_cyc(1);
        chk("R11", "wrap count", int'(count), 0);
        chk("R11", "zero_pulse", int'(zero_pulse), 1);
        chk("R11", "period_pulse cleared", int'(period_pulse), 0);

        // R11 single cycle with ratio 2, prd 2: zero tick at E+6
        start(0, 1, 0, 1, 2);
        wait_cyc(6);
        chk("R11", "zero_pulse on tick", int'(zero_pulse), 1);
        wait_cyc(1);
        chk("R11", "zero_pulse one cycle", int'(zero_pulse), 0);
        chk("R11", "count held between ticks", int'(count), 0);

        // R9 shadow load at zero
        start(0, 0, 0, 0, 3);
        wr_prd(16'd7);
        wait_cyc(3);
        chk("R9", "wrap at old period", int'(count), 0);
        wait_cyc(4);
        chk("R9", "new period after zero", int'(count), 4);

        // R10 immediate load
        start(0, 0, 0, 1, 3);
        wr_prd(16'd7);
        wait_cyc(5);
        chk("R10", "no wrap at old period", int'(count), 6);

        // R8 prescaler restart: ratio 4 then ratio 2 written mid-interval
        start(0, 2, 0, 1, 50);
        wait_cyc(2);
        wr_ctrl(mk_ctrl(0, 1, 0, 1));
        wait_cyc(1);
        chk("R8", "no early tick", int'(count), 0);
        wait_cyc(1);
        chk("R8", "tick after full interval", int'(count), 1);

        // R6 hold mid-count
        start(0, 0, 0, 1, 10);
        wait_cyc(3);
        wr_ctrl(mk_ctrl(3, 0, 0, 1));
        chk("R6", "count at hold entry", int'(count), 4);
        for (int k = 0; k < 6; k++) begin
            wait_cyc(1);
            chk("R6", "count held", int'(count), 4);
            chk("R6", "no strobe", int'(zero_pulse | period_pulse), 0);
        end

        // R12 full-width period in down mode
        start(1, 0, 0, 1, 16'hFFFF);
        wait_cyc(1);
        chk("R12", "reload max", int'(count), 65535);
        chk("R12", "period_pulse at max", int'(period_pulse), 1);
        wait_cyc(1);
        chk("R12", "step below max", int'(count), 65534);
        chk("R12", "period_pulse cleared", int'(period_pulse), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule